// File: doc/BRIEF.md
# Radix-8 Pipelined Add-Compare-Select Array

This block is the path-metric engine of a 64-state trellis decoder for a rate 3/4 convolutional code. Each state has eight incoming branches. For every set of branch metrics it receives, it adds each 5-bit branch metric to the 7-bit path metric of that branch's predecessor state. It then keeps the smallest sum for each state and records which of the eight branches won as a 3-bit decision. All 64 states are updated in parallel. The 64 decisions leave as one 192-bit word, ready to be written to a survivor memory.

The feedback loop is cut by a pipeline register, so one update takes two phases of a small controller. In `S_COLLECT` the array waits for `bm_valid`. On an accepted set it forms all 512 sums and keeps the best of each four-branch half per state, and the transition `S_COLLECT -> S_MERGE` is taken. In `S_MERGE` the two half-winners are compared, the metrics are normalized and clamped, and the results are committed. `S_MERGE -> S_COLLECT` is then taken unconditionally. A new branch metric set can therefore be accepted at most every second cycle. Normalization subtracts half of full scale once every selected sum has reached it, so the metrics stay within 7 bits.

Top module: `acs8_array`

## Requirements
- R1: While `rst_n` is low and after its release, `pm_flat` holds 0 for state 0 and 127 for every other state, `dec_word` is all zero and `out_valid` is low.
- R2: When `bm_valid` is high at a rising edge in `S_COLLECT`, the set is accepted. `out_valid` then goes high after the second rising edge counted from the accepting edge, and it stays high for exactly one cycle.
- R3: The branch metric for state s and branch b sits at bits `(s*8+b)*5` of `bm_flat`. The predecessor of state s on branch b is `(s >> 3) | (b << 3)`. The candidate sum is the predecessor's path metric plus that branch metric.
- R4: Each state keeps its smallest candidate sum. Its decision, the winning branch index, is placed at bits `s*3` of `dec_word`. On equal sums the lowest branch index wins.
- R5: If every one of the 64 selected sums is at least 64, then 64 is subtracted from all of them before they are stored.
- R6: After normalization, any value above 127 is stored as 127.
- R7: `bm_valid` high at the rising edge of an `S_MERGE` cycle is ignored. Its branch metrics have no effect on any output.
- R8: `pm_flat` and `dec_word` change only in the cycle in which `out_valid` is high, and hold their values otherwise.
- R9: At least one state always has a path metric below 64.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| bm_valid | input | 1 | Branch metric set present |
| bm_flat | input | 2560 | 512 branch metrics of 5 bits, indexed by state and branch |
| pm_flat | output | 448 | 64 path metrics of 7 bits, state s at bits s*7 |
| dec_word | output | 192 | 64 survivor decisions of 3 bits, state s at bits s*3 |
| out_valid | output | 1 | New path metrics and decisions present, one-cycle pulse |

## Verification
An accepted branch metric set passes through two registers on the way to the outputs. The stage-one register captures it at the accepting edge, and the committed metrics and `out_valid` change at the next edge. The bench drives the set on a falling edge and leaves one more falling edge for the merge cycle. It then checks `out_valid`, every path metric and every decision at the falling edge after that second rising edge. A further falling edge confirms that `out_valid` has dropped and that the outputs have held. That check also covers the sets pushed in during `S_MERGE`, which must leave no trace.

// File: rtl/acs8_pkg.sv
package acs8_pkg;
    // Two phases of one trellis update: the registered half-select, then the merge.
    typedef enum logic [0:0] {
        S_COLLECT = 1'b0,
        S_MERGE   = 1'b1
    } acs_phase_e;
endpackage

// File: rtl/acs8_grp_sel.sv
module acs8_grp_sel #(
    parameter int N     = 4,
    parameter int SUM_W = 8,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N*SUM_W-1:0] cand_flat,
    output logic [SUM_W-1:0]   best_sum,
    output logic [IDX_W-1:0]   best_idx
);
    // Strict compare: an equal later candidate never displaces an earlier one.
    always_comb begin
        best_sum = cand_flat[SUM_W-1:0];
        best_idx = '0;
        for (int i = 1; i < N; i++) begin
            if (cand_flat[i*SUM_W +: SUM_W] < best_sum) begin
                best_sum = cand_flat[i*SUM_W +: SUM_W];
                best_idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/acs8_ctrl.sv
module acs8_ctrl
    import acs8_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bm_valid,
    output logic st1_load,
    output logic commit
);
    acs_phase_e phase_q, phase_d;

    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= S_COLLECT;
        else        phase_q <= phase_d;
    end

    always_comb begin
        phase_d  = phase_q;
        st1_load = 1'b0;
        commit   = 1'b0;
        unique case (phase_q)
            S_COLLECT: begin
                if (bm_valid) begin
                    st1_load = 1'b1;
                    phase_d  = S_MERGE;
                end
            end
            S_MERGE: begin
                commit  = 1'b1;
                phase_d = S_COLLECT;
            end
            default: phase_d = S_COLLECT;
        endcase
    end
endmodule

// File: rtl/acs8_array.sv
module acs8_array #(
    parameter int NUM_STATES = 64,
    parameter int RADIX      = 8,
    parameter int BM_W       = 5,
    parameter int PM_W       = 7
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   bm_valid,
    input  logic [NUM_STATES*RADIX*BM_W-1:0]       bm_flat,
    output logic [NUM_STATES*PM_W-1:0]             pm_flat,
    output logic [NUM_STATES*$clog2(RADIX)-1:0]    dec_word,
    output logic                                   out_valid
);
    localparam int DEC_W  = $clog2(RADIX);
    localparam int SB_W   = $clog2(NUM_STATES);
    localparam int GRP    = RADIX / 2;
    localparam int GI_W   = DEC_W - 1;
    localparam int SUM_W  = PM_W + 1;
    localparam int HALF   = 2 ** (PM_W - 1);
    localparam int PM_MAX = 2 ** PM_W - 1;

    logic              st1_load, commit;
    logic [PM_W-1:0]   pm_q     [NUM_STATES];
    logic [DEC_W-1:0]  dec_q    [NUM_STATES];
    logic [SUM_W-1:0]  g_best   [NUM_STATES*2];
    logic [GI_W-1:0]   g_idx    [NUM_STATES*2];
    logic [SUM_W-1:0]  st1_best [NUM_STATES*2];
    logic [GI_W-1:0]   st1_idx  [NUM_STATES*2];
    logic [SUM_W-1:0]  sel_sum  [NUM_STATES];
    logic [SUM_W-1:0]  reduced  [NUM_STATES];
    logic [DEC_W-1:0]  sel_dec  [NUM_STATES];
    logic [PM_W-1:0]   pm_next  [NUM_STATES];
    logic [NUM_STATES-1:0] above_half;
    logic              norm;

    acs8_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .bm_valid (bm_valid),
        .st1_load (st1_load),
        .commit   (commit)
    );

    assign norm = &above_half;

    for (genvar s = 0; s < NUM_STATES; s++) begin : g_state
        // Stage one: add and select within each half of the branch set.
        for (genvar h = 0; h < 2; h++) begin : g_half
            logic [GRP*SUM_W-1:0] cand;
            for (genvar i = 0; i < GRP; i++) begin : g_br
                localparam int B = h * GRP + i;
                localparam int P = ((s >> DEC_W) | (B << (SB_W - DEC_W))) % NUM_STATES;
                assign cand[i*SUM_W +: SUM_W] =
                    SUM_W'(pm_q[P]) + SUM_W'(bm_flat[(s*RADIX + B)*BM_W +: BM_W]);
            end
            acs8_grp_sel #(.N(GRP), .SUM_W(SUM_W)) u_sel (
                .cand_flat (cand),
                .best_sum  (g_best[s*2 + h]),
                .best_idx  (g_idx[s*2 + h])
            );
        end

        // Stage two: merge the halves, with the lower half winning ties.
        logic pick_hi;
        assign pick_hi     = st1_best[s*2 + 1] < st1_best[s*2];
        assign sel_sum[s]  = pick_hi ? st1_best[s*2 + 1] : st1_best[s*2];
        assign sel_dec[s]  = pick_hi ? {1'b1, st1_idx[s*2 + 1]} : {1'b0, st1_idx[s*2]};
        assign above_half[s] = sel_sum[s] >= SUM_W'(HALF);
        assign reduced[s]  = sel_sum[s] - (norm ? SUM_W'(HALF) : SUM_W'(0));
        assign pm_next[s]  = (reduced[s] > SUM_W'(PM_MAX)) ? PM_W'(PM_MAX)
                                                           : reduced[s][PM_W-1:0];

        assign pm_flat[s*PM_W +: PM_W]    = pm_q[s];
        assign dec_word[s*DEC_W +: DEC_W] = dec_q[s];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NUM_STATES*2; k++) begin
                st1_best[k] <= '0;
                st1_idx[k]  <= '0;
            end
        end else if (st1_load) begin
            for (int k = 0; k < NUM_STATES*2; k++) begin
                st1_best[k] <= g_best[k];
                st1_idx[k]  <= g_idx[k];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            for (int k = 0; k < NUM_STATES; k++) begin
                pm_q[k]  <= (k == 0) ? '0 : PM_W'(PM_MAX);
                dec_q[k] <= '0;
            end
        end else begin
            out_valid <= commit;
            if (commit) begin
                for (int k = 0; k < NUM_STATES; k++) begin
                    pm_q[k]  <= pm_next[k];
                    dec_q[k] <= sel_dec[k];
                end
            end
        end
    end
endmodule

// File: rtl/acs8_array_chk.sv
module acs8_array_chk #(
    parameter int NUM_STATES = 64,
    parameter int RADIX      = 8,
    parameter int BM_W       = 5,
    parameter int PM_W       = 7
) (
    input logic                                clk,
    input logic                                rst_n,
    input logic                                bm_valid,
    input logic                                out_valid,
    input logic                                st1_load,
    input logic [NUM_STATES*PM_W-1:0]          pm_flat,
    input logic [NUM_STATES*$clog2(RADIX)-1:0] dec_word
);
    logic any_low;
    always_comb begin
        any_low = 1'b0;
        for (int s = 0; s < NUM_STATES; s++)
            if (!pm_flat[s*PM_W + PM_W - 1]) any_low = 1'b1;
    end

    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(bm_valid, 2));

    a_r7_no_back_to_back_load: assert property (@(posedge clk) disable iff (!rst_n)
        st1_load |=> !st1_load);

    a_r8_hold_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(pm_flat) && $stable(dec_word)));

    a_r9_min_below_half: assert property (@(posedge clk) disable iff (!rst_n)
        any_low);
endmodule

bind acs8_array acs8_array_chk #(
    .NUM_STATES (NUM_STATES),
    .RADIX      (RADIX),
    .BM_W       (BM_W),
    .PM_W       (PM_W)
) u_acs8_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bm_valid  (bm_valid),
    .out_valid (out_valid),
    .st1_load  (st1_load),
    .pm_flat   (pm_flat),
    .dec_word  (dec_word)
);

// File: tb/acs8_array_tb_top.sv
module acs8_array_tb_top;
    localparam int NS = 64;
    localparam int NB = 8;
    localparam int BW = 5;
    localparam int PW = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bm_valid = 1'b0;
    logic [NS*NB*BW-1:0] bm_in = '0;
    logic [NS*PW-1:0] pm_flat;
    logic [NS*3-1:0]  dec_word;
    logic out_valid;

    int errors = 0;
    int checks = 0;
    int ref_pm  [NS];
    int ref_dec [NS];

    always #10 clk = ~clk;

    acs8_array dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bm_valid  (bm_valid),
        .bm_flat   (bm_in),
        .pm_flat   (pm_flat),
        .dec_word  (dec_word),
        .out_valid (out_valid)
    );

    task automatic check_int(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic ref_reset();
        for (int s = 0; s < NS; s++) begin
            ref_pm[s]  = (s == 0) ? 0 : 127;
            ref_dec[s] = 0;
        end
    endtask

    task automatic ref_step(input logic [NS*NB*BW-1:0] bm);
        int nv [NS];
        int nd [NS];
        bit all_hi;
        all_hi = 1'b1;
        for (int s = 0; s < NS; s++) begin
            nv[s] = 1000;
            nd[s] = 0;
            for (int b = 0; b < NB; b++) begin
                int p, c;
                p = (s >> 3) | (b << 3);
                c = ref_pm[p] + int'(bm[(s*NB + b)*BW +: BW]);
                if (c < nv[s]) begin nv[s] = c; nd[s] = b; end
            end
            if (nv[s] < 64) all_hi = 1'b0;
        end
        for (int s = 0; s < NS; s++) begin
            int v;
            v = all_hi ? nv[s] - 64 : nv[s];
            ref_pm[s]  = (v > 127) ? 127 : v;
            ref_dec[s] = nd[s];
        end
    endtask

    task automatic check_all(input string req);
        int bad_s, act_pm, act_dec;
        bad_s = -1;
        for (int s = 0; s < NS; s++)
            if (bad_s < 0 && int'(pm_flat[s*PW +: PW]) != ref_pm[s]) bad_s = s;
        act_pm = (bad_s < 0) ? 0 : int'(pm_flat[bad_s*PW +: PW]);
        check_int($sformatf("%s/R3 pm state %0d", req, (bad_s < 0) ? 0 : bad_s),
                  act_pm, (bad_s < 0) ? 0 : ref_pm[bad_s]);
        bad_s = -1;
        for (int s = 0; s < NS; s++)
            if (bad_s < 0 && int'(dec_word[s*3 +: 3]) != ref_dec[s]) bad_s = s;
        act_dec = (bad_s < 0) ? 0 : int'(dec_word[bad_s*3 +: 3]);
        check_int($sformatf("%s/R4 dec state %0d", req, (bad_s < 0) ? 0 : bad_s),
                  act_dec, (bad_s < 0) ? 0 : ref_dec[bad_s]);
    endtask

    function automatic logic [NS*NB*BW-1:0] rand_bm(input int maxv);
        logic [NS*NB*BW-1:0] v;
        for (int k = 0; k < NS*NB; k++) v[k*BW +: BW] = BW'($urandom % (maxv + 1));
        return v;
    endfunction

    function automatic logic [NS*NB*BW-1:0] const_bm(input int val);
        logic [NS*NB*BW-1:0] v;
        for (int k = 0; k < NS*NB; k++) v[k*BW +: BW] = BW'(val);
        return v;
    endfunction

    // Accept at edge k, merge at k+1, outputs checked after k+1 and held after k+2.
    task automatic apply(input logic [NS*NB*BW-1:0] bm, input bit push_extra, input string req);
        @(negedge clk);
        bm_in = bm;
        bm_valid = 1'b1;
        @(negedge clk);
        bm_valid = push_extra;
        if (push_extra) bm_in = rand_bm(31);
        ref_step(bm);
        @(negedge clk);
        bm_valid = 1'b0;
        bm_in = rand_bm(31);
        check_int({req, "/R2 out_valid high"}, int'(out_valid), 1);
        check_all(req);
        @(negedge clk);
        check_int({req, "/R2 out_valid one cycle"}, int'(out_valid), 0);
        check_all({req, "/R7 R8 held"});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        bm_valid = 1'b1;
        repeat (3) @(negedge clk);
        ref_reset();
        check_int("R1 out_valid in reset", int'(out_valid), 0);
        bm_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check_int("R1 out_valid after reset", int'(out_valid), 0);
        check_int("R1 pm state 0", int'(pm_flat[0 +: PW]), 0);
        check_int("R1 pm state 63", int'(pm_flat[63*PW +: PW]), 127);
        check_all("R1 reset state");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        do_reset();

        // R6: first update with maximal metrics saturates the unreachable states.
        apply(const_bm(31), 1'b0, "R6 saturate");
        check_int("R6 pm state 8 clamped", int'(pm_flat[8*PW +: PW]), 127);
        check_int("R6 pm state 0", int'(pm_flat[0 +: PW]), 31);

        // R4: equal branch metrics, ties go to the lowest index.
        apply(const_bm(0), 1'b1, "R4 tie");
        check_int("R4 tie dec state 37", int'(dec_word[37*3 +: 3]), 0);

        // R5: three maximal steps from reset cross half scale and normalize.
        do_reset();
        apply(const_bm(31), 1'b0, "R5 step1");
        apply(const_bm(31), 1'b0, "R5 step2");
        apply(const_bm(31), 1'b0, "R5 step3");
        check_int("R5 normalized pm state 0", int'(pm_flat[0 +: PW]), 29);

        // Mixed random traffic, with ignored pushes during the merge cycle (R7).
        for (int n = 0; n < 40; n++) begin
            int mx;
            mx = (n % 4 == 0) ? 1 : 31;
            apply(rand_bm(mx), (n % 2) == 1, "R3 R4 random");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule